// File: doc/BRIEF.md
# Serial Flash Status Register Controller

This block holds the 16-bit status and control word of a serial NOR flash device. It decides whether each write-type command may proceed. Decoded command strobes arrive one clock at a time from an upstream opcode decoder. The block checks each one against the write-enable latch, the status-register protect bit together with the live level of the write-protect pin, and the protect/complement bits for chip erase. The result is reported as a one-cycle accept or reject pulse.

An accepted program, erase or status write starts a busy period of `BUSY_CYCLES` clocks. The in-progress bit reads 1 for that whole period, and the latch clears when the period ends. A status read returns a snapshot of the word one cycle later, and it is served even while busy. The quad-enable bit is brought out as a mode select that turns the two sideband pins into data lines.

Status word layout: bit 0 in-progress, bit 1 write-enable latch, bits 2..6 protect bits 0..4, bit 7 register protect, bit 9 quad enable, bit 10 one-time lock, bit 14 complement, bit 15 suspend. Bits 8, 11, 12 and 13 are reserved.

Top module: `flash_sr_ctrl`

## Requirements
- R1: After reset the status word is 0, busy and quad mode are 0, and no accept, reject or read-valid pulse is present.
- R2: After a command is accepted, bit 0 and `busy_o` read 1 for exactly `BUSY_CYCLES` consecutive cycles, starting in the cycle after the strobe.
- R3: While bit 1 is 0, a status write, program, sector erase, block erase or chip erase is rejected and changes nothing.
- R4: With bit 7 = 0 and bit 1 = 1, a status write is accepted whatever the level of `wp_n_i`.
- R5: With bit 7 = 1, a status write is rejected while `wp_n_i` is low and accepted (given bit 1 = 1) while it is high.
- R6: A chip erase with bit 1 = 1 is accepted only when bits 2, 3, 4 and 14 are all equal; otherwise it is rejected.
- R7: `quad_mode_o` always equals status bit 9.
- R8: Once bit 10 is 1 it stays 1; a status write can set it but never clear it.
- R9: Write enable sets bit 1 and write disable clears it. Bit 1 also clears in the cycle in which bit 0 falls.
- R10: While bit 0 is 1, every strobe except read status is ignored: no accept or reject pulse and no change to the word.
- R11: An accepted status write copies data bits 2..7, 9 and 14 into the word, ORs data bit 10 in, and leaves bits 0, 1 and 15 unchanged. Bits 8, 11, 12 and 13 always read 0.
- R12: When several strobes arrive in one cycle only one is acted on. The order is write enable, write disable, status write, program, sector erase, block erase, chip erase.
- R13: A read-status strobe gives `rd_valid_o` = 1 in the next cycle, with `rd_data_o` equal to the word as it was in the strobe cycle. This happens even while busy.
- R14: Accept and reject are one-cycle pulses in the cycle after the strobe, on flag bits 0 status write, 1 program, 2 sector erase, 3 block erase, 4 chip erase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wren_i | input | 1 | Write-enable strobe |
| wrdi_i | input | 1 | Write-disable strobe |
| wrsr_i | input | 1 | Status-write strobe |
| wrsr_data_i | input | 16 | Data word for a status write |
| pp_i | input | 1 | Page-program strobe |
| se_i | input | 1 | Sector-erase strobe |
| be_i | input | 1 | Block-erase strobe |
| ce_i | input | 1 | Chip-erase strobe |
| rdsr_i | input | 1 | Read-status strobe |
| wp_n_i | input | 1 | Live write-protect pin level, low active |
| status_o | output | 16 | Current status word |
| wr_accept_o | output | 5 | Accept pulse per write-type command |
| wr_reject_o | output | 5 | Reject pulse per write-type command |
| busy_o | output | 1 | Operation in progress |
| quad_mode_o | output | 1 | Sideband pins serve as quad data lines |
| rd_valid_o | output | 1 | Read-status data valid |
| rd_data_o | output | 16 | Status snapshot for a read |

## Verification
The hardest situation to reach is the register-protect lock. It needs bit 7 set first, and setting it takes an accepted status write, a full busy period and a fresh write enable before the pin level can be tested. The lock test is also only meaningful on a word that also carries the one-time lock and quad enable. The stimulus therefore builds a chain of directed writes: unlock everything, re-enable, then hit the locked and unlocked pin levels back to back while the latch is still set. A random phase follows in which every cycle is compared against a behavioural model. That phase mixes commands into busy periods, drops in colliding strobes and toggles the pin.

// File: rtl/flash_sr_pkg.sv
// Package: shared bit positions, command encodings and masks for the
// flash status register controller. Assumes a 16-bit status word.
package flash_sr_pkg;

    localparam int SR_W    = 16;
    localparam int NUM_WC  = 5;   // write-type commands with accept/reject flags
    localparam int NUM_REQ = 7;   // arbitrated strobes

    // status word bit positions
    localparam int B_WIP = 0;
    localparam int B_WEL = 1;
    localparam int B_BP0 = 2;
    localparam int B_BP1 = 3;
    localparam int B_BP2 = 4;
    localparam int B_BP3 = 5;
    localparam int B_BP4 = 6;
    localparam int B_SRP = 7;
    localparam int B_QE  = 9;
    localparam int B_LB  = 10;
    localparam int B_CMP = 14;
    localparam int B_SUS = 15;

    // flag positions in accept/reject vectors
    localparam int F_WRSR = 0;
    localparam int F_PP   = 1;
    localparam int F_SE   = 2;
    localparam int F_BE   = 3;
    localparam int F_CE   = 4;

    // bits copied straight from a status write
    localparam logic [SR_W-1:0] COPY_MASK =
        (SR_W'(1) << B_BP0) | (SR_W'(1) << B_BP1) | (SR_W'(1) << B_BP2) |
        (SR_W'(1) << B_BP3) | (SR_W'(1) << B_BP4) | (SR_W'(1) << B_SRP) |
        (SR_W'(1) << B_QE)  | (SR_W'(1) << B_CMP);
    // bits a status write leaves alone (in-progress lives in the timer)
    localparam logic [SR_W-1:0] KEEP_MASK =
        (SR_W'(1) << B_WEL) | (SR_W'(1) << B_SUS);
    // one-time bit: set only
    localparam logic [SR_W-1:0] OTP_MASK = SR_W'(1) << B_LB;

    // arbitrated command, enum value = strobe index + 1
    typedef enum logic [2:0] {
        OP_NONE = 3'd0,
        OP_WREN = 3'd1,
        OP_WRDI = 3'd2,
        OP_WRSR = 3'd3,
        OP_PP   = 3'd4,
        OP_SE   = 3'd5,
        OP_BE   = 3'd6,
        OP_CE   = 3'd7
    } op_e;

endpackage

// File: rtl/flash_sr_arb.sv
// Module: fixed-priority pick among simultaneous command strobes.
// Assumes req[0] has the highest priority; output is OP_NONE when idle.
module flash_sr_arb
    import flash_sr_pkg::*;
#(
    parameter int N = NUM_REQ
) (
    input  logic [N-1:0] req,
    output op_e          op
);

    // purpose: scan from lowest to highest priority so the highest wins
    always_comb begin
        op = OP_NONE;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) op = op_e'(3'(i + 1));
        end
    end

endmodule

// File: rtl/flash_sr_gate.sv
// Module: decides accept or reject for the arbitrated command from the
// current status word and the write-protect pin. Pure combinational.
// Assumes nothing is accepted or rejected while an operation is in progress.
module flash_sr_gate
    import flash_sr_pkg::*;
(
    input  op_e               op,
    input  logic [SR_W-1:0]   status,
    input  logic              wp_n,
    output logic [NUM_WC-1:0] accept,
    output logic [NUM_WC-1:0] reject,
    output logic              start
);

    logic busy;
    logic wel;
    logic sr_locked;
    logic ce_ok;

    // purpose: derive the protection conditions from the status word
    always_comb begin
        busy      = status[B_WIP];
        wel       = status[B_WEL];
        sr_locked = status[B_SRP] & ~wp_n;
        ce_ok     = (status[B_BP0] == status[B_BP1]) &&
                    (status[B_BP1] == status[B_BP2]) &&
                    (status[B_BP2] == status[B_CMP]);
    end

    // purpose: map the command to one accept or reject flag
    always_comb begin
        accept = '0;
        reject = '0;
        if (!busy) begin
            case (op)
                OP_WRSR: if (wel && !sr_locked) accept[F_WRSR] = 1'b1;
                         else                   reject[F_WRSR] = 1'b1;
                OP_PP:   if (wel) accept[F_PP] = 1'b1;
                         else     reject[F_PP] = 1'b1;
                OP_SE:   if (wel) accept[F_SE] = 1'b1;
                         else     reject[F_SE] = 1'b1;
                OP_BE:   if (wel) accept[F_BE] = 1'b1;
                         else     reject[F_BE] = 1'b1;
                OP_CE:   if (wel && ce_ok) accept[F_CE] = 1'b1;
                         else              reject[F_CE] = 1'b1;
                default: ;
            endcase
        end
        start = |accept;
    end

endmodule

// File: rtl/flash_sr_timer.sv
// Module: busy-period counter. A start pulse raises wip for exactly
// BUSY_CYCLES clocks; done marks the last of them.
// Assumes start is only given while wip is 0.
module flash_sr_timer #(
    parameter int BUSY_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic wip,
    output logic done
);

    localparam int CW = (BUSY_CYCLES > 1) ? $clog2(BUSY_CYCLES) : 1;

    logic [CW-1:0] cnt_q;

    // purpose: load, count down and release the busy flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wip   <= 1'b0;
            cnt_q <= '0;
        end else if (start) begin
            wip   <= 1'b1;
            cnt_q <= CW'(BUSY_CYCLES - 1);
        end else if (wip) begin
            if (cnt_q == '0) wip <= 1'b0;
            else             cnt_q <= cnt_q - 1'b1;
        end
    end

    // purpose: flag the final busy cycle
    always_comb done = wip && (cnt_q == '0);

    AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !wip); // R10
    AST_WIP_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wip) |-> $past(start)); // R2

endmodule

// File: rtl/flash_sr_ctrl.sv
// Module: top of the flash status register controller. Arbitrates the
// command strobes, gates them, runs the busy timer and keeps the word.
// Assumes strobes are single-cycle pulses from a decoder in this clock domain.
module flash_sr_ctrl
    import flash_sr_pkg::*;
#(
    parameter int BUSY_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wren_i,
    input  logic              wrdi_i,
    input  logic              wrsr_i,
    input  logic [15:0]       wrsr_data_i,
    input  logic              pp_i,
    input  logic              se_i,
    input  logic              be_i,
    input  logic              ce_i,
    input  logic              rdsr_i,
    input  logic              wp_n_i,
    output logic [15:0]       status_o,
    output logic [4:0]        wr_accept_o,
    output logic [4:0]        wr_reject_o,
    output logic              busy_o,
    output logic              quad_mode_o,
    output logic              rd_valid_o,
    output logic [15:0]       rd_data_o
);

    logic [NUM_REQ-1:0] req;
    op_e                op;
    logic [NUM_WC-1:0]  acc;
    logic [NUM_WC-1:0]  rej;
    logic               start;
    logic               wip;
    logic               done;
    logic [SR_W-1:0]    sr_q;
    logic [SR_W-1:0]    sr_wr;

    // purpose: gather strobes in priority order
    always_comb req = {ce_i, be_i, se_i, pp_i, wrsr_i, wrdi_i, wren_i};

    flash_sr_arb #(.N(NUM_REQ)) u_arb (
        .req (req),
        .op  (op)
    );

    flash_sr_gate u_gate (
        .op     (op),
        .status (status_o),
        .wp_n   (wp_n_i),
        .accept (acc),
        .reject (rej),
        .start  (start)
    );

    flash_sr_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .wip   (wip),
        .done  (done)
    );

    // purpose: word presented outside, in-progress bit from the timer
    always_comb begin
        status_o    = sr_q | {{(SR_W-1){1'b0}}, wip};
        busy_o      = wip;
        quad_mode_o = sr_q[B_QE];
    end

    // purpose: next word after an accepted status write
    always_comb sr_wr = (sr_q & KEEP_MASK) | (wrsr_data_i & COPY_MASK) |
                        ((sr_q | wrsr_data_i) & OTP_MASK);

    // purpose: update the stored word and the latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else begin
            if (acc[F_WRSR]) sr_q <= sr_wr;
            if (done)                          sr_q[B_WEL] <= 1'b0;
            else if (!wip && op == OP_WREN)    sr_q[B_WEL] <= 1'b1;
            else if (!wip && op == OP_WRDI)    sr_q[B_WEL] <= 1'b0;
        end
    end

    // purpose: register flag pulses and read-status snapshot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_accept_o <= '0;
            wr_reject_o <= '0;
            rd_valid_o  <= 1'b0;
            rd_data_o   <= '0;
        end else begin
            wr_accept_o <= acc;
            wr_reject_o <= rej;
            rd_valid_o  <= rdsr_i;
            rd_data_o   <= status_o;
        end
    end

    AST_WRSR_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        wr_accept_o[F_WRSR] |-> $past(sr_q[B_WEL])); // R3
    AST_WRSR_PIN_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(status_o[B_SRP]) && !$past(wp_n_i)) |-> !wr_accept_o[F_WRSR]); // R5
    AST_CE_BITS_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
        wr_accept_o[F_CE] |-> ($past(status_o[B_BP0]) == $past(status_o[B_CMP]) &&
                               $past(status_o[B_BP1]) == $past(status_o[B_CMP]) &&
                               $past(status_o[B_BP2]) == $past(status_o[B_CMP]))); // R6
    AST_LB_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(status_o[B_LB]) |-> status_o[B_LB]); // R8
    AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy_o) |-> (wr_accept_o == '0 && wr_reject_o == '0)); // R10
    AST_ONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_accept_o, wr_reject_o})); // R12
    AST_WEL_DROP_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> !status_o[B_WEL]); // R9

endmodule

// File: tb/flash_sr_ctrl_bench.sv
module flash_sr_ctrl_bench;

    localparam int BUSY = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  stb = '0;   // 0 wren,1 wrdi,2 wrsr,3 pp,4 se,5 be,6 ce,7 rdsr
    logic [15:0] wdata = '0;
    logic        wp_n = 1'b1;

    logic [15:0] status;
    logic [4:0]  acc;
    logic [4:0]  rej;
    logic        busy;
    logic        quad;
    logic        rdv;
    logic [15:0] rdd;

    int vectors = 0;
    int fails = 0;
    bit finished = 1'b0;
    bit cmp_on = 1'b0;

    // reference model state
    logic [15:0] m_st;
    int          m_cnt;
    logic [4:0]  m_acc;
    logic [4:0]  m_rej;
    logic        m_rdv;
    logic [15:0] m_rdd;

    always #5ns clk = ~clk;

    flash_sr_ctrl #(.BUSY_CYCLES(BUSY)) u_flash_sr_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .wren_i      (stb[0]),
        .wrdi_i      (stb[1]),
        .wrsr_i      (stb[2]),
        .wrsr_data_i (wdata),
        .pp_i        (stb[3]),
        .se_i        (stb[4]),
        .be_i        (stb[5]),
        .ce_i        (stb[6]),
        .rdsr_i      (stb[7]),
        .wp_n_i      (wp_n),
        .status_o    (status),
        .wr_accept_o (acc),
        .wr_reject_o (rej),
        .busy_o      (busy),
        .quad_mode_o (quad),
        .rd_valid_o  (rdv),
        .rd_data_o   (rdd)
    );

    // behavioural reference, one step per clock
    always @(posedge clk) begin : model
        int op;
        op = 0;
        if (!rst_n) begin
            m_st = '0; m_cnt = 0; m_acc = '0; m_rej = '0; m_rdv = 1'b0; m_rdd = '0;
        end else begin
            m_rdd = m_st;
            m_rdv = stb[7];
            m_acc = '0;
            m_rej = '0;
            for (int i = 6; i >= 0; i--) if (stb[i]) op = i + 1;
            if (m_st[0]) begin
                if (m_cnt == 0) begin m_st[0] = 1'b0; m_st[1] = 1'b0; end
                else m_cnt = m_cnt - 1;
            end else begin
                case (op)
                    1: m_st[1] = 1'b1;
                    2: m_st[1] = 1'b0;
                    3: if (m_st[1] && !(m_st[7] && !wp_n)) begin
                           m_acc[0] = 1'b1;
                           m_st = (m_st & 16'h8002) | (wdata & 16'h42FC) |
                                  ((m_st | wdata) & 16'h0400);
                       end else m_rej[0] = 1'b1;
                    4, 5, 6: if (m_st[1]) m_acc[op-3] = 1'b1; else m_rej[op-3] = 1'b1;
                    7: if (m_st[1] && m_st[2] == m_st[3] && m_st[3] == m_st[4] &&
                           m_st[4] == m_st[14]) m_acc[4] = 1'b1;
                       else m_rej[4] = 1'b1;
                    default: ;
                endcase
                if (m_acc != 0) begin m_st[0] = 1'b1; m_cnt = BUSY - 1; end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (cmp_on && rst_n) begin
            chk(status[0] == m_st[0] && busy == m_st[0], "R2 in-progress", {busy, status[0]}, {2{m_st[0]}});
            chk(status[1] == m_st[1], "R9 latch", status[1], m_st[1]);
            chk(status == m_st, "R11 status word", status, m_st);
            chk(quad == m_st[9], "R7 quad mode", quad, m_st[9]);
            chk(acc == m_acc && rej == m_rej, "R14 flags", {acc, rej}, {m_acc, m_rej});
            chk(rdv == m_rdv && (!m_rdv || rdd == m_rdd), "R13 read", {rdv, rdd}, {m_rdv, m_rdd});
        end
    end

    task automatic cyc(input logic [7:0] s, input logic [15:0] d);
        stb = s;
        wdata = d;
        @(negedge clk);
        #1ns;
        stb = '0;
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 50 && busy; k++) cyc(8'h00, 16'h0000);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    endtask

    initial begin
        #2_000_000ns;
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        #1ns;
        rst_n = 1'b1;
        cmp_on = 1'b1;
        @(negedge clk);
        #1ns;
        chk(status == 16'h0 && !busy && !quad && acc == 0 && rej == 0 && !rdv,
            "R1 reset state", {status, acc, rej}, 0);

        cyc(8'h08, 16'h0);
        chk(rej == 5'b00010 && acc == 0 && status == 16'h0, "R3 program without latch", {acc, rej}, 5'b00010);
        cyc(8'h01, 16'h0);
        chk(status == 16'h0002, "R9 write enable sets latch", status, 16'h0002);
        cyc(8'h08, 16'h0);
        chk(acc == 5'b00010 && busy, "R14 program accepted", {busy, acc}, {1'b1, 5'b00010});
        cyc(8'h04, 16'hFFFF);
        chk(acc == 0 && rej == 0 && status == 16'h0003, "R10 write ignored while busy", {acc, rej}, 0);
        cyc(8'h80, 16'h0);
        chk(rdv && rdd == 16'h0003, "R13 read during busy", rdd, 16'h0003);
        n = 3;
        cyc(8'h00, 16'h0);
        while (busy && n < 20) begin n++; cyc(8'h00, 16'h0); end
        chk(n == BUSY, "R2 busy length", n, BUSY);
        chk(status[1] == 1'b0, "R9 latch cleared at end", status, 16'h0);

        cyc(8'h01, 16'h0);
        cyc(8'h02, 16'h0);
        chk(status == 16'h0, "R9 write disable clears latch", status, 16'h0);

        wp_n = 1'b0;
        cyc(8'h01, 16'h0);
        cyc(8'h04, 16'hFFFF);
        chk(acc == 5'b00001, "R4 write with pin low, unprotected", acc, 5'b00001);
        wait_idle();
        chk(status == 16'h46FC, "R11 written word", status, 16'h46FC);
        chk(quad == 1'b1, "R7 quad follows bit 9", quad, 1'b1);

        cyc(8'h01, 16'h0);
        cyc(8'h04, 16'h0000);
        chk(rej == 5'b00001 && status == 16'h46FE, "R5 locked by pin", {rej, status}, {5'b00001, 16'h46FE});
        wp_n = 1'b1;
        cyc(8'h04, 16'h0000);
        chk(acc == 5'b00001, "R5 unlocked by pin", acc, 5'b00001);
        wait_idle();
        chk(status == 16'h0400, "R8 lock bit stays set", status, 16'h0400);

        cyc(8'h01, 16'h0);
        cyc(8'h40, 16'h0);
        chk(acc == 5'b10000, "R6 chip erase all zero", acc, 5'b10000);
        wait_idle();
        cyc(8'h01, 16'h0);
        cyc(8'h04, 16'h0004);
        wait_idle();
        cyc(8'h01, 16'h0);
        cyc(8'h40, 16'h0);
        chk(rej == 5'b10000 && status[1], "R6 chip erase mixed bits", rej, 5'b10000);
        cyc(8'h04, 16'h401C);
        wait_idle();
        cyc(8'h01, 16'h0);
        cyc(8'h40, 16'h0);
        chk(acc == 5'b10000, "R6 chip erase all one", acc, 5'b10000);
        wait_idle();

        cyc(8'h03, 16'h0);
        chk(status[1] == 1'b1, "R12 enable beats disable", status[1], 1'b1);
        cyc(8'h58, 16'h0);
        chk(acc == 5'b00010, "R12 program beats erases", acc, 5'b00010);
        wait_idle();
        cyc(8'h06, 16'hFFFF);
        chk(acc == 0 && rej == 0 && !status[1], "R12 disable beats status write", {acc, rej}, 0);

        for (int r = 0; r < 3000; r++) begin
            logic [7:0] s;
            s = 8'h00;
            if ($urandom % 3 == 0) s = 8'(1 << ($urandom % 8));
            if ($urandom % 10 == 0) s = s | 8'(1 << ($urandom % 8));
            if ($urandom % 8 == 0) wp_n = ~wp_n;
            cyc(s, 16'($urandom));
        end
        finish_run();
    end

endmodule